// File: doc/BRIEF.md
# Asynchronous HDLC Receive Deframer

This block sits behind a UART character receiver on a byte-oriented HDLC-style link. It takes one received 8-bit character per valid cycle and turns that character stream into frames. It finds the 0x7E delimiters and undoes octet stuffing, where 0x7D marks the next character as XOR-ed with 0x20. It also silently drops control characters that a 32-bit receive map marks as link-inserted. Payload bytes leave the block one at a time. The two trailing frame check bytes are held back and never emitted.

When a frame closes, the block raises a single-cycle frame-done event with exactly one status flag. The flags are good, CRC error, short, or aborted. The check is CRC-CCITT in its reflected form. One delimiter may close one frame and open the next one. Runs of delimiters with nothing between them produce no event. An escape character followed directly by a delimiter aborts the frame in progress.

Top module: `ahdlc_rx_deframer`

## Requirements
- R1: After reset every output is 0, and characters received before the first 0x7E delimiter produce no output.
- R2: Inside a frame, each data byte appears on `outData` with `outValid` high in the cycle after the data character that follows it by two positions arrives. The last two bytes before the closing delimiter (the check sequence) are never emitted.
- R3: A 0x7D character is consumed and not emitted. The next accepted character has 0x20 XOR-ed into it and is used as data; this holds even when that character is itself 0x7D.
- R4: A received character with value below 32 is dropped with no output when bit `ctrlMap[value]` is 1. This holds in any state, and it does not cancel a pending escape.
- R5: On a closing 0x7E after 4 or more data bytes, one cycle later `doneEvt` and `stGood` are 1 if the CRC register ends at 0xF0B8. The register is initialised to 0xFFFF and updated LSB first with polynomial 0x8408 over all data bytes, including the check bytes.
- R6: Under the conditions of R5 but with any other CRC residue, `doneEvt` and `stCrcErr` are 1 instead.
- R7: A frame of 1 to 3 data bytes gives `doneEvt` with `stShort` and never with `stGood`.
- R8: The delimiter that closes one frame also opens the next, so back-to-back frames need only one delimiter between them.
- R9: A 0x7E with no data bytes since the previous delimiter produces no event and no data.
- R10: 0x7D followed by 0x7E gives, one cycle later, `doneEvt` with `stAbort`. The partial frame is dropped without a CRC verdict, and that 0x7E opens a new frame.
- R11: The four status flags are all 0 outside `doneEvt`, exactly one is 1 during it, and no cycle without an input character is followed by any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chValid | input | 1 | A received character is present this cycle |
| chData | input | 8 | Received character |
| ctrlMap | input | 32 | Receive control map; bit n set drops character value n |
| outValid | output | 1 | Payload byte on `outData` |
| outData | output | 8 | Payload byte |
| doneEvt | output | 1 | Frame-done event, one cycle |
| stGood | output | 1 | Frame passed CRC (with `doneEvt`) |
| stCrcErr | output | 1 | Frame failed CRC (with `doneEvt`) |
| stShort | output | 1 | Frame had fewer than 4 bytes (with `doneEvt`) |
| stAbort | output | 1 | Frame aborted by escape-delimiter (with `doneEvt`) |

## Verification
Frames are sent with gaps of idle cycles, so the two-byte holdback is shown to count characters and not cycles. Payloads are chosen to contain the delimiter, the escape and mapped control values, so stuffed and plain traffic are both decoded. The map-character noise placed between an escape and its partner shows whether a dropped character wrongly cancels the escape. Back-to-back frames on one shared delimiter, runs of bare delimiters, corrupted check bytes, two-byte frames and mid-frame aborts each take a different branch of the closing decision.

// File: rtl/ahdlc_rx_pkg.sv
`timescale 1ns/1ps
package ahdlc_rx_pkg;
  localparam logic [7:0]  FLAG_CH  = 8'h7E;
  localparam logic [7:0]  ESC_CH   = 8'h7D;
  localparam logic [7:0]  XOR_MASK = 8'h20;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h8408;
  localparam logic [15:0] CRC_GOOD = 16'hF0B8;

  // strobes from control to datapath, valid only for the current character
  typedef struct packed {
    logic       push;
    logic [7:0] val;
    logic       close;
    logic       abort;
  } rxStrobe_t;

  // byte-parallel reflected CRC-CCITT step
  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/ahdlc_rx_ctrl.sv
`timescale 1ns/1ps
module ahdlc_rx_ctrl
  import ahdlc_rx_pkg::*;
#(
  parameter int MAP_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chValid,
  input  logic [7:0]       chData,
  input  logic [MAP_W-1:0] ctrlMap,
  output rxStrobe_t        strobe
);
  localparam int IDX_W = $clog2(MAP_W);

  logic inFrame, escPend;
  logic nextIn, nextEsc;
  logic mapHit;

  assign mapHit = (int'(chData) < MAP_W) && ctrlMap[chData[IDX_W-1:0]];

  always_comb begin
    strobe  = '0;
    nextIn  = inFrame;
    nextEsc = escPend;
    if (chValid && !mapHit) begin
      if (chData == FLAG_CH) begin
        if (escPend)      strobe.abort = 1'b1;
        else if (inFrame) strobe.close = 1'b1;
        nextIn  = 1'b1;
        nextEsc = 1'b0;
      end else if (inFrame) begin
        if (escPend) begin
          strobe.push = 1'b1;
          strobe.val  = chData ^ XOR_MASK;
          nextEsc     = 1'b0;
        end else if (chData == ESC_CH) begin
          nextEsc = 1'b1;
        end else begin
          strobe.push = 1'b1;
          strobe.val  = chData;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      escPend <= 1'b0;
    end else begin
      inFrame <= nextIn;
      escPend <= nextEsc;
    end
  end
endmodule

// File: rtl/ahdlc_rx_datapath.sv
`timescale 1ns/1ps
module ahdlc_rx_datapath
  import ahdlc_rx_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobe_t  strobe,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       doneEvt,
  output logic       stGood,
  output logic       stCrcErr,
  output logic       stShort,
  output logic       stAbort
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

  logic [15:0]      crcReg;
  logic [CNT_W-1:0] byteCnt;
  logic [7:0]       holdNew, holdOld;
  logic             isShort, crcOk;

  assign isShort = byteCnt < CNT_MIN;
  assign crcOk   = crcReg == CRC_GOOD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg   <= CRC_INIT;
      byteCnt  <= '0;
      holdNew  <= '0;
      holdOld  <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      doneEvt  <= 1'b0;
      stGood   <= 1'b0;
      stCrcErr <= 1'b0;
      stShort  <= 1'b0;
      stAbort  <= 1'b0;
    end else begin
      outValid <= 1'b0;
      doneEvt  <= 1'b0;
      stGood   <= 1'b0;
      stCrcErr <= 1'b0;
      stShort  <= 1'b0;
      stAbort  <= 1'b0;
      if (strobe.push) begin
        crcReg  <= crcByte(crcReg, strobe.val);
        if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
        holdNew <= strobe.val;
        holdOld <= holdNew;
        if (byteCnt >= CNT_TWO) begin
          outValid <= 1'b1;
          outData  <= holdOld;
        end
      end
      if (strobe.close) begin
        if (byteCnt != '0) begin
          doneEvt  <= 1'b1;
          stShort  <= isShort;
          stGood   <= !isShort && crcOk;
          stCrcErr <= !isShort && !crcOk;
        end
        crcReg  <= CRC_INIT;
        byteCnt <= '0;
      end
      if (strobe.abort) begin
        doneEvt <= 1'b1;
        stAbort <= 1'b1;
        crcReg  <= CRC_INIT;
        byteCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ahdlc_rx_deframer.sv
`timescale 1ns/1ps
module ahdlc_rx_deframer
  import ahdlc_rx_pkg::*;
#(
  parameter int MAP_W   = 32,
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chValid,
  input  logic [7:0]       chData,
  input  logic [MAP_W-1:0] ctrlMap,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             doneEvt,
  output logic             stGood,
  output logic             stCrcErr,
  output logic             stShort,
  output logic             stAbort
);
  rxStrobe_t strobe;

  ahdlc_rx_ctrl #(.MAP_W(MAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chValid(chValid), .chData(chData),
    .ctrlMap(ctrlMap), .strobe(strobe)
  );

  ahdlc_rx_datapath #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .outValid(outValid), .outData(outData), .doneEvt(doneEvt),
    .stGood(stGood), .stCrcErr(stCrcErr), .stShort(stShort), .stAbort(stAbort)
  );
endmodule

// File: rtl/ahdlc_rx_deframer_chk.sv
`timescale 1ns/1ps
module ahdlc_rx_deframer_chk #(
  parameter int MAP_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             chValid,
  input logic [7:0]       chData,
  input logic [MAP_W-1:0] ctrlMap,
  input logic             outValid,
  input logic [7:0]       outData,
  input logic             doneEvt,
  input logic             stGood,
  input logic             stCrcErr,
  input logic             stShort,
  input logic             stAbort
);
  localparam int IDX_W = $clog2(MAP_W);
  logic mapHit;
  assign mapHit = (int'(chData) < MAP_W) && ctrlMap[chData[IDX_W-1:0]];

  a_r11_one_status: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> $onehot({stGood, stCrcErr, stShort, stAbort}));

  a_r11_quiet_status: assert property (@(posedge clk) disable iff (!rstN)
    !doneEvt |-> ({stGood, stCrcErr, stShort, stAbort} == 4'b0000));

  a_r11_no_idle_output: assert property (@(posedge clk) disable iff (!rstN)
    !chValid |=> (!outValid && !doneEvt));

  a_r4_map_drop: assert property (@(posedge clk) disable iff (!rstN)
    (chValid && mapHit) |=> (!outValid && !doneEvt));

  a_r9_flag_no_data: assert property (@(posedge clk) disable iff (!rstN)
    (chValid && chData == 8'h7E) |=> !outValid);

  a_r7_short_not_good: assert property (@(posedge clk) disable iff (!rstN)
    stShort |-> !stGood);
endmodule

bind ahdlc_rx_deframer ahdlc_rx_deframer_chk #(.MAP_W(MAP_W)) u_chk (.*);

// File: tb/ahdlc_rx_deframer_bench.sv
`timescale 1ns/1ps
module ahdlc_rx_deframer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chValid = 1'b0;
  logic [7:0]  chData = 8'h00;
  logic [31:0] ctrlMap = 32'h0;
  logic        outValid, doneEvt, stGood, stCrcErr, stShort, stAbort;
  logic [7:0]  outData;

  always #2.5 clk = ~clk;

  ahdlc_rx_deframer u_ahdlc_rx_deframer (
    .clk(clk), .rstN(rstN), .chValid(chValid), .chData(chData), .ctrlMap(ctrlMap),
    .outValid(outValid), .outData(outData), .doneEvt(doneEvt),
    .stGood(stGood), .stCrcErr(stCrcErr), .stShort(stShort), .stAbort(stAbort)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  int          mIn = 0, mEsc = 0;
  logic [7:0]  frameQ[$];
  logic [31:0] mapReg = 32'h0;
  logic        eV, eE, eG, eC, eS, eA;
  logic [7:0]  eD;

  function automatic logic [15:0] bitCrc(input logic [15:0] init, input logic [7:0] q[$]);
    logic [15:0] c = init;
    foreach (q[k]) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ q[k][b];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  task automatic clearExp();
    eV = 0; eD = 8'h00; eE = 0; eG = 0; eC = 0; eS = 0; eA = 0;
  endtask

  task automatic modelPush(input logic [7:0] b);
    frameQ.push_back(b);
    if (frameQ.size() >= 3) begin
      eV = 1;
      eD = frameQ[frameQ.size() - 3];
    end
  endtask

  task automatic modelChar(input logic [7:0] c);
    clearExp();
    if (c < 8'd32 && mapReg[c[4:0]]) return;
    if (c == 8'h7E) begin
      if (mEsc != 0) begin
        eE = 1; eA = 1;
      end else if (mIn != 0 && frameQ.size() > 0) begin
        eE = 1;
        if (frameQ.size() < 4) eS = 1;
        else if (bitCrc(16'hFFFF, frameQ) == 16'hF0B8) eG = 1;
        else eC = 1;
      end
      frameQ.delete();
      mIn = 1; mEsc = 0;
    end else if (mIn != 0) begin
      if (mEsc != 0) begin
        modelPush(c ^ 8'h20); mEsc = 0;
      end else if (c == 8'h7D) mEsc = 1;
      else modelPush(c);
    end
  endtask

  task automatic compare();
    checks++;
    if (outValid !== eV || (eV && outData !== eD) || doneEvt !== eE ||
        stGood !== eG || stCrcErr !== eC || stShort !== eS || stAbort !== eA) begin
      fails++;
      $display("FAIL %s: got v=%0b d=%h evt=%0b gcsa=%0b%0b%0b%0b exp v=%0b d=%h evt=%0b gcsa=%0b%0b%0b%0b",
               tag, outValid, outData, doneEvt, stGood, stCrcErr, stShort, stAbort,
               eV, eD, eE, eG, eC, eS, eA);
    end
  endtask

  // one cycle: check last expectation, drive next input, predict
  task automatic step(input logic v, input logic [7:0] c);
    @(negedge clk);
    compare();
    chValid = v;
    chData  = c;
    ctrlMap = mapReg;
    if (v) modelChar(c);
    else clearExp();
  endtask

  task automatic sendCh(input logic [7:0] c);
    step(1'b1, c);
  endtask

  // stuff and send a frame with its check bytes, then a closing delimiter
  task automatic sendFrame(input logic [7:0] pay[$], input bit bad, input bit noise, input int gapEvery);
    logic [7:0] all[$];
    logic [15:0] fcs;
    int n = 0;
    all = pay;
    fcs = ~bitCrc(16'hFFFF, pay);
    all.push_back(fcs[7:0] ^ (bad ? 8'h01 : 8'h00));
    all.push_back(fcs[15:8]);
    foreach (all[k]) begin
      logic [7:0] b = all[k];
      if (noise) sendCh(8'h11);
      if (b == 8'h7E || b == 8'h7D || (b < 8'd32 && mapReg[b[4:0]])) begin
        sendCh(8'h7D);
        if (noise) sendCh(8'h11);
        sendCh(b ^ 8'h20);
      end else sendCh(b);
      n++;
      if (gapEvery > 0 && (n % gapEvery) == 0) begin
        step(1'b0, 8'h00); step(1'b0, 8'h00);
      end
    end
    sendCh(8'h7E);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clearExp();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state and hunting before first delimiter
    tag = "R1";
    step(1'b0, 8'h00);
    sendCh(8'h41); sendCh(8'h55); sendCh(8'h20); step(1'b0, 8'h00);

    // R2 and R5: plain good frame with idle gaps
    tag = "R2_R5";
    sendCh(8'h7E);
    sendFrame('{8'h10, 8'hA5, 8'h3C, 8'hFF, 8'h01}, 0, 0, 2);
    // R8: next frame opened by the shared delimiter
    tag = "R8";
    sendFrame('{8'h42, 8'h43, 8'h44}, 0, 0, 0);
    // R9: bare delimiters
    tag = "R9";
    sendCh(8'h7E); sendCh(8'h7E); step(1'b0, 8'h00); sendCh(8'h7E);
    // R3: payload needing escapes, including double-escape value
    tag = "R3";
    sendFrame('{8'h7E, 8'h7D, 8'h5D, 8'h7D, 8'h00, 8'h20}, 0, 0, 3);
    // R4: map drops, noise between escape and partner
    tag = "R4";
    mapReg = 32'h000A_0002;
    step(1'b0, 8'h00);
    sendFrame('{8'h01, 8'h11, 8'h7E, 8'h99, 8'h13}, 0, 1, 0);
    sendCh(8'h11); sendCh(8'h13); sendCh(8'h01);
    // R6: corrupt check bytes
    tag = "R6";
    sendFrame('{8'hDE, 8'hAD, 8'hBE, 8'hEF}, 1, 0, 0);
    // R7: short frames
    tag = "R7";
    sendCh(8'h61); sendCh(8'h62); sendCh(8'h7E);
    sendCh(8'h63); sendCh(8'h7E);
    // R10: abort mid frame, delimiter opens following frame
    tag = "R10";
    sendCh(8'h31); sendCh(8'h32); sendCh(8'h33); sendCh(8'h7D); sendCh(8'h7E);
    sendFrame('{8'h77, 8'h66, 8'h55}, 0, 0, 0);
    sendCh(8'h7D); sendCh(8'h7E);
    // R11: idle after traffic
    tag = "R11";
    mapReg = 32'h0;
    step(1'b0, 8'h00); step(1'b0, 8'h00);
    sendFrame('{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE}, 0, 0, 1);
    step(1'b0, 8'h00); step(1'b0, 8'h00);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule